// File: doc/BRIEF.md
# Cache Policy Precedence Resolver

This block decides, for every memory access, how the cache hierarchy may treat it. Three sources of control are merged. The first is a pair of global bits, a cache-disable bit and a write-policy bit, held in a control register. The second is a per-access page attribute pair, cache-disable and write-through. The third is a memory type taken from a bank of base/mask range registers, with a default type for addresses that no range covers. The result is four flags: cacheable (lookups may hit), write-back (as opposed to write-through), fill (new lines may be allocated), and an enable for the third-level cache.

The page and range controls are merged so that the more restrictive of the two always applies. The global cache-disable bit then overrides both. A parameter selects how a set cache-disable bit behaves. In one variant, the caches keep answering hits but never allocate. In the other, caching is switched off entirely. In both variants the write-policy bit has no effect while cache-disable is set.

Accesses use a valid/ready port with a single output register. A request is accepted when `req_valid` and `req_ready` are both high, and its policy appears with `rsp_valid` on the following cycle. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. If `rsp_valid` is high while `rsp_ready` is low, the response is held unchanged and no new request is accepted. Register writes go through a plain write strobe with a select and an index. No handshake is needed for them.

Top module: `cache_policy_resolver`

## Requirements
- R1: After reset, global cache-disable and write-policy are both 1. All range registers are invalid, the default type is UC, third-level disable is 0, and `rsp_valid` is 0.
- R2: `cfg_sel`=0 writes the control register, with cache-disable at data bit 30 and write-policy at bit 29. `cfg_sel`=1 writes the misc register, with third-level disable at bit 6 and the default type in bits 1:0. A write applies to requests accepted on later cycles. A request accepted in the same cycle as the write still sees the old value.
- R3: Types are encoded UC=0, WT=1, WB=2, and code 3 is treated as UC. The page pair {cache-disable, write-through} maps 1x to UC, 01 to WT and 00 to WB.
- R4: `cfg_sel`=2 writes range `cfg_idx` with its base in bits 31:12 and its type in bits 1:0. `cfg_sel`=3 writes its mask in bits 31:12 and its valid flag in bit 11. A range matches when it is valid and the masked address bits equal the masked base. Among matching ranges, UC beats WT and WT beats WB. An address that no range matches takes the default type.
- R5: With both global bits 0, the effective type is the more restrictive of the page and range types. Cacheable is set when that type is not UC, write-back is set only for WB, and fill equals cacheable.
- R6: With cache-disable 0 and write-policy 1, a WB result is demoted to write-through. Cacheable and fill are unaffected.
- R7: With VARIANT=0 and cache-disable 1, the write-policy bit is ignored. Cacheable follows the merged type, while write-back and fill are both 0.
- R8: With VARIANT=1 and cache-disable 1, cacheable, write-back, fill and third-level enable are all 0, whatever the write-policy, page and range settings.
- R9: The third-level enable equals cacheable and not third-level disable. The third-level disable bit changes no other flag.
- R10: The response follows acceptance by one cycle. `req_ready` = !`rsp_valid` || `rsp_ready`. A response that is not taken stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 misc, 2 range base, 3 range mask |
| cfg_idx | input | 3 | Range index for selects 2 and 3 |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Physical address of the access |
| req_pcd | input | 1 | Page cache-disable attribute |
| req_pwt | input | 1 | Page write-through attribute |
| rsp_valid | output | 1 | Policy response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_cacheable | output | 1 | Lookups may hit in the caches |
| rsp_writeback | output | 1 | Write-back (1) or write-through (0) |
| rsp_fill | output | 1 | Line allocation allowed |
| rsp_l3_en | output | 1 | Third-level cache may be used |

## Verification
A stuck or mis-decoded configuration bit shows up on the very next response after the affected access is accepted, as a wrong cacheable, write-back or fill flag. A sweep over every global, page and range combination therefore exposes it within a handful of cycles. A fault in range priority shows only when ranges overlap, so overlapping ranges of different types are programmed on purpose. A broken hold under back-pressure shows as response flags that change while `rsp_ready` is low, one cycle after the stall begins.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam logic [1:0] MT_UC  = 2'd0;
  localparam logic [1:0] MT_WT  = 2'd1;
  localparam logic [1:0] MT_WB  = 2'd2;
  localparam logic [1:0] MT_RSV = 2'd3;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_MISC  = 2'd1,
    SEL_RBASE = 2'd2,
    SEL_RMASK = 2'd3
  } cfg_sel_e;

  localparam int CTRL_CD_BIT   = 30;
  localparam int CTRL_NW_BIT   = 29;
  localparam int MISC_L3D_BIT  = 6;
  localparam int RMASK_VLD_BIT = 11;
  localparam int PAGE_SHIFT    = 12;

  typedef struct packed {
    logic cacheable;
    logic writeback;
    logic fill;
    logic l3_en;
  } policy_t;

  // Lower code is more restrictive; the reserved code folds to UC.
  function automatic logic [1:0] mt_min(logic [1:0] a, logic [1:0] b);
    logic [1:0] na;
    logic [1:0] nb;
    na = (a == MT_RSV) ? MT_UC : a;
    nb = (b == MT_RSV) ? MT_UC : b;
    return (na < nb) ? na : nb;
  endfunction
endpackage

// File: rtl/cpr_cfg_regs.sv
module cpr_cfg_regs
  import cpr_pkg::*;
#(
  parameter  int NUM_RANGES = 8,
  parameter  int ADDR_W     = 32,
  parameter  int DATA_W     = 32,
  localparam int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
  localparam int TAG_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_sel,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic                              cd,
  output logic                              nw,
  output logic                              l3_dis,
  output logic [1:0]                        dflt_type,
  output logic [NUM_RANGES-1:0][TAG_W-1:0]  rng_base,
  output logic [NUM_RANGES-1:0][TAG_W-1:0]  rng_mask,
  output logic [NUM_RANGES-1:0]             rng_vld,
  output logic [NUM_RANGES-1:0][1:0]        rng_type
);
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd        <= 1'b1;
      nw        <= 1'b1;
      l3_dis    <= 1'b0;
      dflt_type <= MT_UC;
      rng_base  <= '0;
      rng_mask  <= '0;
      rng_vld   <= '0;
      rng_type  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_CTRL: begin
          cd <= cfg_wdata[CTRL_CD_BIT];
          nw <= cfg_wdata[CTRL_NW_BIT];
        end
        SEL_MISC: begin
          l3_dis    <= cfg_wdata[MISC_L3D_BIT];
          dflt_type <= cfg_wdata[1:0];
        end
        SEL_RBASE: begin
          for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_idx == IDX_W'(i)) begin
              rng_base[i] <= cfg_wdata[ADDR_W-1:PAGE_SHIFT];
              rng_type[i] <= cfg_wdata[1:0];
            end
          end
        end
        default: begin
          for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_idx == IDX_W'(i)) begin
              rng_mask[i] <= cfg_wdata[ADDR_W-1:PAGE_SHIFT];
              rng_vld[i]  <= cfg_wdata[RMASK_VLD_BIT];
            end
          end
        end
      endcase
    end
  end

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_CTRL) |=> (cd == $past(cfg_wdata[CTRL_CD_BIT]) && nw == $past(cfg_wdata[CTRL_NW_BIT]))); // R2
endmodule

// File: rtl/cpr_range_lookup.sv
module cpr_range_lookup
  import cpr_pkg::*;
#(
  parameter  int NUM_RANGES = 8,
  parameter  int ADDR_W     = 32,
  localparam int TAG_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic [TAG_W-1:0]                  addr_tag,
  input  logic [NUM_RANGES-1:0][TAG_W-1:0]  rng_base,
  input  logic [NUM_RANGES-1:0][TAG_W-1:0]  rng_mask,
  input  logic [NUM_RANGES-1:0]             rng_vld,
  input  logic [NUM_RANGES-1:0][1:0]        rng_type,
  input  logic [1:0]                        dflt_type,
  output logic [1:0]                        hit_type
);
  logic [NUM_RANGES-1:0] hit;
  logic [NUM_RANGES-1:0] uc_hit;
  logic [NUM_RANGES-1:0] wt_hit;
  logic [NUM_RANGES-1:0] wb_hit;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
    assign hit[g]    = rng_vld[g] && (((addr_tag ^ rng_base[g]) & rng_mask[g]) == '0);
    assign uc_hit[g] = hit[g] && (rng_type[g] == MT_UC || rng_type[g] == MT_RSV);
    assign wt_hit[g] = hit[g] && (rng_type[g] == MT_WT);
    assign wb_hit[g] = hit[g] && (rng_type[g] == MT_WB);
  end

  always_comb begin
    if (|uc_hit)      hit_type = MT_UC;
    else if (|wt_hit) hit_type = MT_WT;
    else if (|wb_hit) hit_type = MT_WB;
    else              hit_type = dflt_type;
  end
endmodule

// File: rtl/cpr_merge.sv
module cpr_merge
  import cpr_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic       cd,
  input  logic       nw,
  input  logic       l3_dis,
  input  logic       pcd,
  input  logic       pwt,
  input  logic [1:0] rng_type,
  output policy_t    pol
);
  logic [1:0] page_type;
  logic [1:0] eff_type;
  policy_t    open_pol;
  policy_t    dis_pol;
  policy_t    base_pol;

  assign page_type = pcd ? MT_UC : (pwt ? MT_WT : MT_WB);
  assign eff_type  = mt_min(page_type, rng_type);

  always_comb begin
    open_pol.cacheable = (eff_type != MT_UC);
    open_pol.writeback = (eff_type == MT_WB) && !nw;
    open_pol.fill      = (eff_type != MT_UC);
    open_pol.l3_en     = 1'b0;
  end

  if (VARIANT == 0) begin : g_nofill
    always_comb begin
      dis_pol.cacheable = (eff_type != MT_UC);
      dis_pol.writeback = 1'b0;
      dis_pol.fill      = 1'b0;
      dis_pol.l3_en     = 1'b0;
    end
  end else begin : g_off
    assign dis_pol = '0;
  end

  always_comb begin
    base_pol  = cd ? dis_pol : open_pol;
    pol       = base_pol;
    pol.l3_en = base_pol.cacheable && !l3_dis;
  end
endmodule

// File: rtl/cache_policy_resolver.sv
module cache_policy_resolver
  import cpr_pkg::*;
#(
  parameter  int NUM_RANGES = 8,
  parameter  int ADDR_W     = 32,
  parameter  int DATA_W     = 32,
  parameter  int VARIANT    = 0,
  localparam int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
  localparam int TAG_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_pcd,
  input  logic              req_pwt,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_cacheable,
  output logic              rsp_writeback,
  output logic              rsp_fill,
  output logic              rsp_l3_en
);
  logic                             cd, nw, l3_dis;
  logic [1:0]                       dflt_type;
  logic [NUM_RANGES-1:0][TAG_W-1:0] rng_base, rng_mask;
  logic [NUM_RANGES-1:0]            rng_vld;
  logic [NUM_RANGES-1:0][1:0]       rng_type;
  logic [1:0]                       hit_type;
  policy_t                          pol, pol_q;
  logic                             accept;
  logic                             unused_low;

  assign unused_low = ^req_addr[PAGE_SHIFT-1:0];

  cpr_cfg_regs #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cd(cd), .nw(nw), .l3_dis(l3_dis), .dflt_type(dflt_type),
    .rng_base(rng_base), .rng_mask(rng_mask), .rng_vld(rng_vld), .rng_type(rng_type)
  );

  cpr_range_lookup #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W)) u_lookup (
    .addr_tag(req_addr[ADDR_W-1:PAGE_SHIFT]), .rng_base(rng_base), .rng_mask(rng_mask),
    .rng_vld(rng_vld), .rng_type(rng_type), .dflt_type(dflt_type), .hit_type(hit_type)
  );

  cpr_merge #(.VARIANT(VARIANT)) u_merge (
    .cd(cd), .nw(nw), .l3_dis(l3_dis), .pcd(req_pcd), .pwt(req_pwt),
    .rng_type(hit_type), .pol(pol)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      pol_q     <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      pol_q     <= pol;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_cacheable = pol_q.cacheable;
  assign rsp_writeback = pol_q.writeback;
  assign rsp_fill      = pol_q.fill;
  assign rsp_l3_en     = pol_q.l3_en;

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(pol_q))); // R10
  AST_NO_FILL_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cd) |=> !rsp_fill && !rsp_writeback); // R7
  AST_L3_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && l3_dis) |=> !rsp_l3_en); // R9
  AST_NW_BLOCKS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && nw) |=> !rsp_writeback); // R6
  AST_WB_NEEDS_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!rsp_writeback || rsp_cacheable)); // R5

  if (VARIANT != 0) begin : g_off_chk
    AST_OFF_VARIANT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cd) |=> (!rsp_cacheable && !rsp_l3_en)); // R8
  end
endmodule

// File: tb/sim_cache_policy_resolver.sv
module sim_cache_policy_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {cd, nw, pcd, pwt, range_type[1:0], exp cacheable, exp writeback, exp fill}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0_0_0_0_10_111, 9'b0_0_0_0_01_101, 9'b0_0_0_0_00_000, 9'b0_0_0_1_10_101,
    9'b0_0_1_0_10_000, 9'b0_0_1_1_10_000, 9'b0_0_0_1_00_000, 9'b0_1_0_0_10_101,
    9'b1_0_0_0_10_100, 9'b1_1_0_0_10_100, 9'b1_1_1_0_10_000, 9'b0_0_0_0_11_000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [2:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_pcd = 1'b0;
  logic req_pwt = 1'b0;
  logic rsp_ready = 1'b1;
  logic rdy0, rdy1, vld0, vld1;
  logic c0, w0, f0, l0, c1, w1, f1, l1;
  logic [3:0] p0, p1;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_policy_resolver #(.VARIANT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(rdy0), .req_addr(req_addr),
    .req_pcd(req_pcd), .req_pwt(req_pwt), .rsp_valid(vld0), .rsp_ready(rsp_ready),
    .rsp_cacheable(c0), .rsp_writeback(w0), .rsp_fill(f0), .rsp_l3_en(l0));

  cache_policy_resolver #(.VARIANT(1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(rdy1), .req_addr(req_addr),
    .req_pcd(req_pcd), .req_pwt(req_pwt), .rsp_valid(vld1), .rsp_ready(rsp_ready),
    .rsp_cacheable(c1), .rsp_writeback(w1), .rsp_fill(f1), .rsp_l3_en(l1));

  assign p0 = {c0, w0, f0, l0};
  assign p1 = {c1, w1, f1, l1};

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] ref_pol(bit variant, bit cd, bit nw, bit pcd, bit pwt,
                                         logic [1:0] rt, bit l3d);
    logic [1:0] pt, r, m;
    bit c, wb, fl;
    pt = pcd ? 2'd0 : (pwt ? 2'd1 : 2'd2);
    r  = (rt == 2'd3) ? 2'd0 : rt;
    m  = (pt < r) ? pt : r;
    if (!cd) begin
      c = (m != 0); wb = (m == 2) && !nw; fl = c;
    end else if (!variant) begin
      c = (m != 0); wb = 1'b0; fl = 1'b0;
    end else begin
      c = 1'b0; wb = 1'b0; fl = 1'b0;
    end
    return {c, wb, fl, c && !l3d};
  endfunction

  task automatic wr(logic [1:0] sel, logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(logic [31:0] a, logic pcd, logic pwt);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_pcd = pcd; req_pwt = pwt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", {3'b0, vld0}, 4'b0000);
    chk("R10 req_ready in reset", {3'b0, rdy0}, 4'b0001);
    rst_n = 1'b1;
    // R1: range miss falls to default UC
    acc(32'h2000_0000, 1'b0, 1'b0);
    chk("R1 default UC after reset", p0, 4'b0000);
    chk("R10 rsp_valid one cycle after accept", {3'b0, vld0}, 4'b0001);
    // R1: cache-disable set at reset -> no-fill variant hits but never fills
    wr(2'd2, 3'd0, 32'h1000_0002);
    wr(2'd3, 3'd0, 32'hF000_0800);
    acc(32'h1000_0000, 1'b0, 1'b0);
    chk("R1 CD=1 at reset (no-fill)", p0, 4'b1001);
    chk("R1 CD=1 at reset (off)", p1, 4'b0000);

    // Table walk: R3 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, 3'd0, {1'b0, VEC[i][8], VEC[i][7], 29'b0});
      wr(2'd2, 3'd0, 32'h1000_0000 | {30'b0, VEC[i][4:3]});
      acc(32'h1000_0000, VEC[i][6], VEC[i][5]);
      chk($sformatf("R5 R7 table row %0d", i), p0, {VEC[i][2:0], VEC[i][2]});
    end

    // Full sweep against the reference: R3 R5 R6 R7 R8
    for (int k = 0; k < 48; k++) begin
      bit cd, nw, pcd, pwt;
      logic [1:0] rt;
      cd = k[5]; nw = k[4]; pcd = k[3]; pwt = k[2];
      rt = (k[1:0] == 2'd3) ? 2'd2 : k[1:0];
      wr(2'd0, 3'd0, {1'b0, cd, nw, 29'b0});
      wr(2'd2, 3'd0, 32'h1000_0000 | {30'b0, rt});
      acc(32'h1000_0000, pcd, pwt);
      chk($sformatf("R7 sweep %0d", k), p0, ref_pol(1'b0, cd, nw, pcd, pwt, rt, 1'b0));
      chk($sformatf("R8 sweep %0d", k), p1, ref_pol(1'b1, cd, nw, pcd, pwt, rt, 1'b0));
    end

    // R2: a write in the same cycle as a request is not yet seen
    wr(2'd0, 3'd0, 32'h0000_0000);
    wr(2'd2, 3'd0, 32'h1000_0002);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h4000_0000;
    req_valid = 1'b1; req_addr = 32'h1000_0000; req_pcd = 1'b0; req_pwt = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R2 same-cycle write sees old value", p1, 4'b1111);
    acc(32'h1000_0000, 1'b0, 1'b0);
    chk("R2 write applies next request", p1, 4'b0000);

    // R4: overlapping ranges and priority
    wr(2'd0, 3'd0, 32'h0000_0000);
    wr(2'd3, 3'd0, 32'h0000_0000);
    wr(2'd1, 3'd0, 32'h0000_0002);
    wr(2'd2, 3'd1, 32'h4000_0002);
    wr(2'd3, 3'd1, 32'hC000_0800);
    wr(2'd2, 3'd2, 32'h4000_0001);
    wr(2'd3, 3'd2, 32'hF000_0800);
    acc(32'h4000_0000, 1'b0, 1'b0);
    chk("R4 WT beats WB", p0, 4'b1011);
    acc(32'h5000_0000, 1'b0, 1'b0);
    chk("R4 single WB match", p0, 4'b1111);
    wr(2'd2, 3'd3, 32'h4000_0000);
    wr(2'd3, 3'd3, 32'hFFFF_F800);
    acc(32'h4000_0000, 1'b0, 1'b0);
    chk("R4 UC beats WT", p0, 4'b0000);
    acc(32'h4000_1000, 1'b0, 1'b0);
    chk("R4 UC range mask boundary", p0, 4'b1011);
    acc(32'h8000_0000, 1'b0, 1'b0);
    chk("R4 miss takes default WB", p0, 4'b1111);
    acc(32'h8000_0000, 1'b1, 1'b0);
    chk("R3 page UC restricts default WB", p0, 4'b0000);

    // R9: third-level disable leaves other flags alone
    wr(2'd1, 3'd0, 32'h0000_0042);
    acc(32'h8000_0000, 1'b0, 1'b0);
    chk("R9 L3 disable", p0, 4'b1110);
    wr(2'd1, 3'd0, 32'h0000_0002);

    // R10: back-pressure holds the response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h8000_0000; req_pcd = 1'b0; req_pwt = 1'b0;
    @(negedge clk);
    chk("R10 req_ready low when stalled", {3'b0, rdy0}, 4'b0000);
    req_pcd = 1'b1;
    @(negedge clk);
    chk("R10 response held under stall", p0, 4'b1111);
    chk("R10 rsp_valid held under stall", {3'b0, vld0}, 4'b0001);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next request taken on drain", p0, 4'b0000);
    chk("R10 rsp_valid after drain and accept", {3'b0, vld0}, 4'b0001);
    @(negedge clk);
    chk("R10 rsp_valid drops when idle", {3'b0, vld0}, 4'b0000);

    finish_run();
  end
endmodule